// File: doc/BRIEF.md
# Link Pulse Burst Generator

This block produces the link-integrity and auto-negotiation pulse train that a twisted-pair Ethernet transmitter places on an otherwise idle line. In fast mode it sends a 16-bit code word as a burst of seventeen clock pulses. A data pulse is placed halfway between two clock pulses for every bit that is 1. The burst repeats on a fixed period. In normal mode it sends one lone pulse per period instead, and a mute input can silence those lone pulses completely.

Every interval is derived from a clock-frequency parameter, given in cycles per microsecond. The pulse width is 100 ns rounded up to whole cycles, with a minimum of one. The clock-pulse spacing is 125 µs. The data slot sits at half that spacing, rounded down. The repetition period defaults to 16 ms. The caller is expected to choose parameters that satisfy three conditions: the pulse is shorter than half the spacing, the burst fits inside one period, and the period is more than one cycle.

Top module: `lp_gen`

## Requirements
- R1: While reset is held, and after reset with `en` low, `pulse_out` and `burst_done` are 0.
- R2: Every pulse is high for exactly W = max(1, ceil(100 * CLK_MHZ / 1000)) consecutive cycles. It starts in the cycle after the one in which the pulse is triggered.
- R3: With `fast_mode` = 1, a burst has 17 clock pulses, numbered k = 0..16. Clock pulse k starts k*CP cycles after the first one, where CP = 125 * CLK_MHZ.
- R4: Bit k of the code word (k = 0..15, bit 0 first) with value 1 adds a data pulse starting k*CP + CP/2 cycles after the first clock pulse. A bit with value 0 adds no pulse in that slot.
- R5: The code word is captured in the cycle that starts a burst. A change during a burst first shows in the next burst.
- R6: Burst (or lone pulse) starts repeat every P = REP_US * CLK_MHZ cycles. The first start is taken in the first cycle that `en` is high, so its pulse appears after the first enabled clock edge.
- R7: `burst_done` is high for exactly one cycle, 16*CP + W cycles after the first clock pulse of a burst started. That is the first cycle after the seventeenth clock pulse ends.
- R8: With `fast_mode` = 0 and `idle_pulse_off` = 0, each period carries exactly one pulse at its start and no data pulses, and `burst_done` stays 0.
- R9: With `fast_mode` = 0 and `idle_pulse_off` = 1, no pulse is emitted.
- R10: Driving `en` low clears the pulse, the burst and the period count at the next edge. `pulse_out` then stays 0 until `en` rises again, and the timing restarts from the new rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Generator enable; low clears all timing state |
| fast_mode | input | 1 | 1 = code-word bursts, 0 = lone pulses |
| idle_pulse_off | input | 1 | 1 = suppress lone pulses in normal mode |
| code_word | input | 16 | Word sent in each burst, bit 0 first |
| pulse_out | output | 1 | Line pulse |
| burst_done | output | 1 | One-cycle strobe after the last clock pulse of a burst |

## Verification
The assertions assume `fast_mode` and `idle_pulse_off` hold steady for the length of a burst, and that `code_word` may change at any time. They also rely on parameters where the pulse width is below half the clock spacing and the whole burst ends well before the next period. The stimulus therefore changes the mode and mute inputs only while `en` is low. It changes the code word only in the middle of a burst, which is exactly the case covered by the capture rule. A small configuration of one cycle per microsecond and an 8 ms period keeps whole bursts short enough to compare every single cycle against a model in the bench.

// File: rtl/lp_pkg.sv
package lp_pkg;

  // Nanoseconds to whole cycles, rounded up, never less than one.
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  // Microseconds to cycles.
  function automatic int unsigned us_to_cycles(input int unsigned us, input int unsigned mhz);
    return us * mhz;
  endfunction

  // Position of the data slot inside one clock-pulse interval.
  function automatic int unsigned data_slot(input int unsigned spacing);
    return spacing / 2;
  endfunction

  typedef enum logic {
    LP_NORMAL = 1'b0,
    LP_FAST   = 1'b1
  } lp_mode_e;

endpackage

// File: rtl/lp_period_timer.sv
module lp_period_timer #(
  parameter int unsigned PERIOD = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  assign tick_o = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: consecutive period starts are never adjacent
  a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/lp_pulse_shaper.sv
module lp_pulse_shaper #(
  parameter int unsigned WIDTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int unsigned RW = $clog2(WIDTH + 1);

  logic [RW-1:0] rem;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      rem <= '0;
    end else if (trig_i) begin
      rem <= RW'(WIDTH);
    end else if (rem != '0) begin
      rem <= rem - 1'b1;
    end
  end

  assign pulse_o = (rem != '0);

  // R2: a pulse only begins after a trigger
  a_r2_rise_after_trig: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(trig_i));

  // R2: a trigger while running always yields a high output next cycle
  a_r2_trig_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && run) |=> pulse_o);

endmodule

// File: rtl/lp_burst_seq.sv
module lp_burst_seq #(
  parameter int unsigned BITS    = 16,
  parameter int unsigned SPACING = 3125,
  parameter int unsigned HALF    = 1562,
  parameter int unsigned WIDTH   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            launch_i,
  input  logic [BITS-1:0] word_i,
  output logic            busy_o,
  output logic            trig_o,
  output logic            done_o
);
  localparam int unsigned PW = $clog2(SPACING);
  localparam int unsigned KW = $clog2(BITS + 1);
  localparam int unsigned IW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(SPACING - 1);
  localparam logic [PW-1:0] PH_DATA = PW'(HALF);
  localparam logic [PW-1:0] PH_END  = PW'(WIDTH);
  localparam logic [KW-1:0] K_LAST  = KW'(BITS);

  logic            busy;
  logic [KW-1:0]   k;
  logic [PW-1:0]   ph;
  logic [BITS-1:0] word_q;
  logic            done_q;
  logic            start_burst;
  logic            clk_slot;
  logic            data_slot_hit;
  logic            burst_end;

  assign start_burst   = launch_i && !busy;
  assign clk_slot      = busy && (ph == '0);
  assign data_slot_hit = busy && (ph == PH_DATA) && (k < K_LAST) && word_q[k[IW-1:0]];
  assign burst_end     = busy && (k == K_LAST) && (ph == PH_END);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      busy   <= 1'b0;
      k      <= '0;
      ph     <= '0;
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= burst_end;
      if (start_burst) begin
        busy   <= 1'b1;
        k      <= '0;
        ph     <= PW'(1);
        word_q <= word_i;
      end else if (burst_end) begin
        busy <= 1'b0;
        k    <= '0;
        ph   <= '0;
      end else if (busy) begin
        if (ph == PH_LAST) begin
          ph <= '0;
          k  <= k + 1'b1;
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy;
  assign trig_o = start_burst || clk_slot || data_slot_hit;
  assign done_o = done_q;

  // R3: the pulse index never passes the seventeenth clock pulse
  a_r3_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (k <= K_LAST));

  // R4: inside a burst, triggers fall only on a clock slot or the data slot
  a_r4_slot_only: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && busy && ph != '0) |-> (ph == PH_DATA));

  // R5: the captured word holds for the whole burst
  a_r5_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run && !burst_end) |=> $stable(word_q));

endmodule

// File: rtl/lp_gen.sv
module lp_gen #(
  parameter int unsigned CLK_MHZ    = 25,
  parameter int unsigned PULSE_NS   = 100,
  parameter int unsigned SPACING_NS = 125000,
  parameter int unsigned REP_US     = 16000,
  parameter int unsigned WORD_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              fast_mode,
  input  logic              idle_pulse_off,
  input  logic [WORD_W-1:0] code_word,
  output logic              pulse_out,
  output logic              burst_done
);
  import lp_pkg::*;

  localparam int unsigned W_CYC   = ns_to_cycles(PULSE_NS, CLK_MHZ);
  localparam int unsigned CP_CYC  = ns_to_cycles(SPACING_NS, CLK_MHZ);
  localparam int unsigned HALF    = data_slot(CP_CYC);
  localparam int unsigned REP_CYC = us_to_cycles(REP_US, CLK_MHZ);

  lp_mode_e mode;
  logic     tick;
  logic     seq_busy;
  logic     seq_trig;
  logic     seq_done;
  logic     lone_trig;
  logic     any_trig;
  logic     fast_launch;

  assign mode        = lp_mode_e'(fast_mode);
  assign fast_launch = tick && (mode == LP_FAST);
  assign lone_trig   = tick && (mode == LP_NORMAL) && !idle_pulse_off;
  assign any_trig    = seq_trig || lone_trig;

  lp_period_timer #(.PERIOD(REP_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (en),
    .tick_o (tick)
  );

  lp_burst_seq #(
    .BITS    (WORD_W),
    .SPACING (CP_CYC),
    .HALF    (HALF),
    .WIDTH   (W_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (en),
    .launch_i (fast_launch),
    .word_i   (code_word),
    .busy_o   (seq_busy),
    .trig_o   (seq_trig),
    .done_o   (seq_done)
  );

  lp_pulse_shaper #(.WIDTH(W_CYC)) u_shape (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en),
    .trig_i  (any_trig),
    .pulse_o (pulse_out)
  );

  assign burst_done = seq_done;

  // R10: a disabled generator is silent from the next edge on
  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pulse_out);

  // R7: the done strobe lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);

  // R7: the done strobe comes right as the last clock pulse falls
  a_r7_done_follows_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> (!pulse_out && $past(pulse_out)));

  // R9: a muted normal-mode period start produces no pulse
  a_r9_muted_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fast_mode && idle_pulse_off && !seq_busy && !pulse_out) |=> !pulse_out);

  // R8: no burst activity starts in normal mode
  a_r8_no_burst_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_mode && !seq_busy) |=> !seq_busy);

endmodule

// File: tb/sim_lp_gen.sv
module sim_lp_gen;
  localparam int MHZ = 1;
  localparam int REP_US = 8000;
  // Bench-side timing, from the requirement formulas
  localparam int BW   = ((100 * MHZ + 999) / 1000 == 0) ? 1 : (100 * MHZ + 999) / 1000;
  localparam int BCP  = 125 * MHZ;
  localparam int BHF  = BCP / 2;
  localparam int BREP = REP_US * MHZ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic fast_mode = 1'b0;
  logic idle_pulse_off = 1'b0;
  logic [15:0] code_word = '0;
  logic pulse_out;
  logic burst_done;

  int vectors = 0;
  int miscompares = 0;
  int fail_prints = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lp_gen #(.CLK_MHZ(MHZ), .REP_US(REP_US)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .fast_mode(fast_mode),
    .idle_pulse_off(idle_pulse_off), .code_word(code_word),
    .pulse_out(pulse_out), .burst_done(burst_done)
  );

  function automatic bit exp_pulse(int p, logic [15:0] w, bit fast, bit off);
    bit r = 0;
    for (int d = 0; d < BW; d++) begin
      int t = p - d;
      if (t >= 0) begin
        if (fast) begin
          if ((t % BCP) == 0 && (t / BCP) <= 16) r = 1;
          if ((t % BCP) == BHF && (t / BCP) < 16 && w[t / BCP]) r = 1;
        end else if (t == 0 && !off) begin
          r = 1;
        end
      end
    end
    return r;
  endfunction

  task automatic check(string tag, logic act, logic exp, int at);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      if (fail_prints < 20) begin
        $display("FAIL %s cycle %0d: actual=%b expected=%b", tag, at, act, exp);
        fail_prints++;
      end
    end
  endtask

  // Runs whole periods, comparing both outputs every cycle.
  task automatic run_case(string ptag, bit fast, bit off, logic [15:0] w0,
                          logic [15:0] w1, int switch_at, int periods);
    logic [15:0] lw = '0;
    fast_mode = fast;
    idle_pulse_off = off;
    code_word = w0;
    en = 1'b1;
    for (int n = 0; n < periods * BREP; n++) begin
      int p;
      @(posedge clk); #1;
      p = n % BREP;
      if (p == 0) lw = code_word;   // R5: word seen in the start cycle
      check(ptag, pulse_out, exp_pulse(p, lw, fast, off), n);
      check("R7 burst_done", burst_done, (fast && p == 16 * BCP + BW) ? 1'b1 : 1'b0, n);
      if (n == switch_at) code_word = w1;
    end
    en = 1'b0;
    for (int n = 0; n < 300; n++) begin
      @(posedge clk); #1;
      check("R10 disabled output", pulse_out, 1'b0, n);
      check("R10 disabled strobe", burst_done, 1'b0, n);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset pulse", pulse_out, 1'b0, 0);
    check("R1 reset strobe", burst_done, 1'b0, 0);
    rst_n = 1'b1;
    for (int n = 0; n < 20; n++) begin
      @(posedge clk); #1;
      check("R1 idle pulse", pulse_out, 1'b0, n);
      check("R1 idle strobe", burst_done, 1'b0, n);
    end
    // R3 R4 R6 with a word change mid-burst for R5
    run_case("R3 R4 R5 R6 burst", 1'b1, 1'b0, 16'hA5C3, 16'h8001, 500, 2);
    // R3 only clock pulses
    run_case("R3 clock-only burst", 1'b1, 1'b0, 16'h0000, 16'h0000, -1, 1);
    // R4 every data slot filled, width per R2
    run_case("R4 R2 full burst", 1'b1, 1'b0, 16'hFFFF, 16'hFFFF, -1, 1);
    // R8 lone pulses, word ignored
    run_case("R8 lone pulse", 1'b0, 1'b0, 16'h5A5A, 16'h5A5A, -1, 2);
    // R9 muted lone pulses
    run_case("R9 muted", 1'b0, 1'b1, 16'hFFFF, 16'hFFFF, -1, 2);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R6 watchdog: actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule